// File: doc/BRIEF.md
# Interrupt Controller Command Sequencer

This block is the host-facing front end of an eight-line priority interrupt controller. Software talks to it through two byte addresses. Address 0 carries the command bytes: the start of initialization, the read/poll selection, and the end-of-interrupt and priority commands. Address 1 carries the mask register in normal operation and the remaining initialization bytes while a setup sequence is running. A small step machine counts those setup bytes. One of them is optional, and a bit of the starting byte decides whether it is expected.

The request and priority logic sit outside this block. They feed in the pending and in-service registers and the currently winning line. The sequencer turns each command into a registered single-cycle strobe with a line number. It holds the mask, the vector base and the mode flags, and it answers reads. A poll read is armed by one command and used by one read. That read returns the winning line and tells the priority logic to retire it.

Top module: `pic_cmd_seq`

## Requirements
- R1: After a synchronous reset, the mask, vector base, init phase (0 = normal), all mode flags, poll, command strobes, command line and read data are all zero.
- R2: A write to address 0 with data bit 4 set clears the mask, vector base, read-select, poll, special mask, auto-EOI, rotate flag and nested mode. It sets the init phase to 1, remembers data bit 0 as "mode byte expected", and pulses strobe bit 6 (init, which tells the priority logic to drop its output).
- R3: In phase 1, an address-1 write loads the vector base from data bits 7:3 and moves to phase 2. In phase 2, an address-1 write moves to phase 3 if a mode byte is expected and to phase 0 otherwise. In phase 3, an address-1 write sets nested mode from bit 4 and auto-EOI from bit 1, then returns to phase 0. The mask does not change during phases 1 to 3.
- R4: In phase 0, an address-1 write loads the mask register with the data byte.
- R5: A write to address 0 with bit 4 clear and bit 3 set produces no strobe. Bit 2 set arms poll. Bit 1 set loads read-select from bit 0 (1 = in-service, 0 = pending). Bit 6 set loads special mask from bit 5.
- R6: Any other address-0 write decodes bits 7:5. Code 1 pulses strobe bit 0 (non-specific EOI). Code 5 pulses bit 1 (rotating EOI). Code 3 pulses bit 2 (specific EOI). Code 6 pulses bit 3 (set priority). Code 7 pulses bit 4 (rotating specific EOI). Codes 3, 6 and 7 put data bits 2:0 on the command line; every other case puts 0 there. Codes 0 and 4 load the rotate-on-auto-EOI flag from bit 7. Code 2 has no effect.
- R7: At most one strobe bit is high in any cycle. A strobe appears in the cycle after its write and lasts exactly one cycle.
- R8: A read while poll is armed does one of two things. If a qualifying line exists, the read data becomes that line number in bits 2:0 with zeros above, and strobe bit 5 (poll clear) pulses with that line. If none exists, the read data becomes 7 and no strobe pulses. In both cases poll disarms.
- R9: A read without poll returns the in-service or pending register at address 0, chosen by read-select, and the mask at address 1. Read data is registered, so it appears one cycle after the read and holds until the next accepted read.
- R10: The vector output is the vector base in bits 7:3 with the winning line number in bits 2:0.
- R11: A read in the same cycle as a write is ignored: read data holds and poll stays armed. The write takes effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 1 | Register address bit |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data byte |
| pend_in | input | 8 | Pending register from the request logic |
| insvc_in | input | 8 | In-service register from the priority logic |
| best_valid | input | 1 | A qualifying line exists |
| best_line | input | 3 | Number of the winning line |
| mask_reg | output | 8 | Interrupt mask register |
| vec_base | output | 5 | Vector base (upper vector bits) |
| vector | output | 8 | Vector for the winning line |
| init_phase | output | 2 | Initialization step, 0 = normal |
| auto_eoi | output | 1 | Automatic end-of-interrupt mode |
| rot_on_aeoi | output | 1 | Rotate priority on automatic EOI |
| nested_mode | output | 1 | Special fully nested mode |
| special_mask | output | 1 | Special mask mode |
| read_isr | output | 1 | Read-select: 1 in-service, 0 pending |
| poll_armed | output | 1 | Next read is a poll read |
| cmd_stb | output | 7 | One-hot command strobes to the priority logic |
| cmd_line | output | 3 | Line number that goes with the strobe |
| rdata | output | 8 | Registered read data |

## Verification
The hardest case to reach is the tail of the setup sequence. The optional mode byte is taken only when the starting byte asked for it, and the mask must stay untouched while address-1 bytes are being used as setup data. The bench first sweeps all 256 address-0 bytes against an arithmetic model. That sweep ends on 0xFF, which leaves the block in phase 1 with a mode byte expected, so the full four-byte sequence follows without extra setup. A second sequence then uses the three-byte form. Poll reads are driven for every line and for the empty case. Each one is followed by an ordinary read to show that poll has disarmed. A read issued together with a write is also driven, to show that the read is dropped.

// File: rtl/pic_cmd_pkg.sv
package pic_cmd_pkg;
  localparam int STB_W         = 7;
  localparam int S_EOI_NS      = 0;
  localparam int S_EOI_ROT     = 1;
  localparam int S_EOI_SPEC    = 2;
  localparam int S_SET_PRIO    = 3;
  localparam int S_EOI_ROTSPEC = 4;
  localparam int S_POLL_CLR    = 5;
  localparam int S_INIT        = 6;

  typedef enum logic [1:0] {
    PH_NORMAL  = 2'd0,
    PH_BASE    = 2'd1,
    PH_CASCADE = 2'd2,
    PH_MODE    = 2'd3
  } init_phase_e;
endpackage

// File: rtl/pic_ocw_decode.sv
module pic_ocw_decode
  import pic_cmd_pkg::*;
#(
  parameter int DW = 8,
  localparam int LW = $clog2(DW)
) (
  input  logic             wr_en,
  input  logic             addr,
  input  logic [DW-1:0]    wdata,
  output logic             init_hit,
  output logic             rdcmd_hit,
  output logic             rot_load,
  output logic [STB_W-1:0] stb_wr,
  output logic [LW-1:0]    line_wr
);
  logic [2:0] code;
  logic       op_hit;

  assign code      = wdata[7:5];
  assign init_hit  = wr_en && !addr && wdata[4];
  assign rdcmd_hit = wr_en && !addr && !wdata[4] && wdata[3];
  assign op_hit    = wr_en && !addr && !wdata[4] && !wdata[3];
  assign rot_load  = op_hit && (code[1:0] == 2'b00);

  always_comb begin
    stb_wr  = '0;
    line_wr = '0;
    if (init_hit) begin
      stb_wr[S_INIT] = 1'b1;
    end else if (op_hit) begin
      case (code)
        3'd1: stb_wr[S_EOI_NS]  = 1'b1;
        3'd5: stb_wr[S_EOI_ROT] = 1'b1;
        3'd3: begin
          stb_wr[S_EOI_SPEC] = 1'b1;
          line_wr            = wdata[LW-1:0];
        end
        3'd6: begin
          stb_wr[S_SET_PRIO] = 1'b1;
          line_wr            = wdata[LW-1:0];
        end
        3'd7: begin
          stb_wr[S_EOI_ROTSPEC] = 1'b1;
          line_wr               = wdata[LW-1:0];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pic_init_fsm.sv
module pic_init_fsm
  import pic_cmd_pkg::*;
#(
  parameter int DW = 8,
  localparam int LW     = $clog2(DW),
  localparam int BASE_W = DW - LW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              addr,
  input  logic [DW-1:0]     wdata,
  input  logic              init_hit,
  output init_phase_e       phase,
  output logic [BASE_W-1:0] vec_base,
  output logic              nested,
  output logic              aeoi
);
  logic need_mode;
  logic unused_bits;

  assign unused_bits = wdata[2];

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_NORMAL;
      need_mode <= 1'b0;
      vec_base  <= '0;
      nested    <= 1'b0;
      aeoi      <= 1'b0;
    end else if (init_hit) begin
      phase     <= PH_BASE;
      need_mode <= wdata[0];
      vec_base  <= '0;
      nested    <= 1'b0;
      aeoi      <= 1'b0;
    end else if (wr_en && addr) begin
      case (phase)
        PH_BASE: begin
          vec_base <= wdata[DW-1 -: BASE_W];
          phase    <= PH_CASCADE;
        end
        PH_CASCADE: phase <= need_mode ? PH_MODE : PH_NORMAL;
        PH_MODE: begin
          nested <= wdata[4];
          aeoi   <= wdata[1];
          phase  <= PH_NORMAL;
        end
        default: ;
      endcase
    end
  end

  AST_CASCADE_EXIT: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_CASCADE && wr_en && addr) |=> (phase == PH_MODE || phase == PH_NORMAL)); // R3
  AST_MODE_EXIT: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_MODE && wr_en && addr) |=> (phase == PH_NORMAL)); // R3
endmodule

// File: rtl/pic_read_mux.sv
module pic_read_mux #(
  parameter int DW = 8,
  localparam int LW = $clog2(DW)
) (
  input  logic          addr,
  input  logic          poll,
  input  logic          rd_sel,
  input  logic [DW-1:0] pend,
  input  logic [DW-1:0] insvc,
  input  logic [DW-1:0] mask,
  input  logic          best_valid,
  input  logic [LW-1:0] best_line,
  output logic [DW-1:0] rdata_nxt
);
  always_comb begin
    if (poll)
      rdata_nxt = best_valid ? {{(DW-LW){1'b0}}, best_line} : DW'(7);
    else if (!addr)
      rdata_nxt = rd_sel ? insvc : pend;
    else
      rdata_nxt = mask;
  end
endmodule

// File: rtl/pic_cmd_seq.sv
module pic_cmd_seq
  import pic_cmd_pkg::*;
#(
  parameter int DW = 8,
  localparam int LW     = $clog2(DW),
  localparam int BASE_W = DW - LW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [DW-1:0]     wdata,
  input  logic [DW-1:0]     pend_in,
  input  logic [DW-1:0]     insvc_in,
  input  logic              best_valid,
  input  logic [LW-1:0]     best_line,
  output logic [DW-1:0]     mask_reg,
  output logic [BASE_W-1:0] vec_base,
  output logic [DW-1:0]     vector,
  output logic [1:0]        init_phase,
  output logic              auto_eoi,
  output logic              rot_on_aeoi,
  output logic              nested_mode,
  output logic              special_mask,
  output logic              read_isr,
  output logic              poll_armed,
  output logic [STB_W-1:0]  cmd_stb,
  output logic [LW-1:0]     cmd_line,
  output logic [DW-1:0]     rdata
);
  logic             init_hit, rdcmd_hit, rot_load, rd_go;
  logic [STB_W-1:0] stb_wr;
  logic [LW-1:0]    line_wr;
  logic [DW-1:0]    rdata_nxt;
  init_phase_e      phase;

  assign rd_go = rd_en && !wr_en;

  pic_ocw_decode #(.DW(DW)) u_dec (
    .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .init_hit(init_hit), .rdcmd_hit(rdcmd_hit), .rot_load(rot_load),
    .stb_wr(stb_wr), .line_wr(line_wr)
  );

  pic_init_fsm #(.DW(DW)) u_init (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .init_hit(init_hit), .phase(phase), .vec_base(vec_base),
    .nested(nested_mode), .aeoi(auto_eoi)
  );

  pic_read_mux #(.DW(DW)) u_rmux (
    .addr(addr), .poll(poll_armed), .rd_sel(read_isr),
    .pend(pend_in), .insvc(insvc_in), .mask(mask_reg),
    .best_valid(best_valid), .best_line(best_line), .rdata_nxt(rdata_nxt)
  );

  assign init_phase = phase;
  assign vector     = {vec_base, best_line};

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_reg     <= '0;
      read_isr     <= 1'b0;
      poll_armed   <= 1'b0;
      special_mask <= 1'b0;
      rot_on_aeoi  <= 1'b0;
      cmd_stb      <= '0;
      cmd_line     <= '0;
      rdata        <= '0;
    end else begin
      cmd_stb  <= stb_wr;
      cmd_line <= line_wr;
      if (init_hit) begin
        mask_reg     <= '0;
        read_isr     <= 1'b0;
        poll_armed   <= 1'b0;
        special_mask <= 1'b0;
        rot_on_aeoi  <= 1'b0;
      end else if (rdcmd_hit) begin
        if (wdata[2]) poll_armed   <= 1'b1;
        if (wdata[1]) read_isr     <= wdata[0];
        if (wdata[6]) special_mask <= wdata[5];
      end else if (rot_load) begin
        rot_on_aeoi <= wdata[7];
      end else if (wr_en && addr && phase == PH_NORMAL) begin
        mask_reg <= wdata;
      end
      if (rd_go) begin
        rdata <= rdata_nxt;
        if (poll_armed) begin
          poll_armed <= 1'b0;
          if (best_valid) begin
            cmd_stb             <= '0;
            cmd_stb[S_POLL_CLR] <= 1'b1;
            cmd_line            <= best_line;
          end
        end
      end
    end
  end

  AST_STB_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cmd_stb)); // R7
  AST_INIT_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !addr && wdata[4]) |=> (mask_reg == '0 && init_phase == 2'd1 && cmd_stb[S_INIT] && !poll_armed)); // R2
  AST_MASK_HELD: assert property (@(posedge clk) disable iff (rst)
    (init_phase != 2'd0 && !(wr_en && !addr && wdata[4])) |=> $stable(mask_reg)); // R3
  AST_POLL_DISARM: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !wr_en && poll_armed) |=> !poll_armed); // R8
  AST_POLL_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !wr_en && poll_armed && !best_valid) |=> (rdata == DW'(7) && cmd_stb == '0)); // R8
  AST_RW_CLASH: assert property (@(posedge clk) disable iff (rst)
    (wr_en && rd_en) |=> $stable(rdata)); // R11
endmodule

// File: tb/sim_pic_cmd_seq.sv
module sim_pic_cmd_seq;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       addr = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = '0, pend_in = '0, insvc_in = '0;
  logic       best_valid = 1'b0;
  logic [2:0] best_line = '0;
  logic [7:0] mask_reg, vector, rdata;
  logic [4:0] vec_base;
  logic [1:0] init_phase;
  logic       auto_eoi, rot_on_aeoi, nested_mode, special_mask, read_isr, poll_armed;
  logic [6:0] cmd_stb;
  logic [2:0] cmd_line;

  int checks = 0, errors = 0;
  bit done = 0;

  // model state
  logic [7:0] e_mask;
  logic [4:0] e_base;
  logic [1:0] e_phase;
  logic       e_need, e_aeoi, e_nest, e_rot, e_smm, e_rsel, e_poll;
  logic [6:0] e_stb;
  logic [2:0] e_line;

  always #5 clk = ~clk;

  pic_cmd_seq u0 (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata),
    .pend_in(pend_in), .insvc_in(insvc_in), .best_valid(best_valid), .best_line(best_line),
    .mask_reg(mask_reg), .vec_base(vec_base), .vector(vector), .init_phase(init_phase),
    .auto_eoi(auto_eoi), .rot_on_aeoi(rot_on_aeoi), .nested_mode(nested_mode),
    .special_mask(special_mask), .read_isr(read_isr), .poll_armed(poll_armed),
    .cmd_stb(cmd_stb), .cmd_line(cmd_line), .rdata(rdata)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic a);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic model_wr0(input logic [7:0] d);
    e_stb = '0; e_line = '0;
    if (d[4]) begin
      e_stb = 7'h40; e_mask = 0; e_base = 0; e_rsel = 0; e_poll = 0; e_smm = 0;
      e_aeoi = 0; e_rot = 0; e_nest = 0; e_phase = 2'd1; e_need = d[0];
    end else if (d[3]) begin
      if (d[2]) e_poll = 1'b1;
      if (d[1]) e_rsel = d[0];
      if (d[6]) e_smm = d[5];
    end else begin
      case (d[7:5])
        3'd0, 3'd4: e_rot = d[7];
        3'd1: e_stb = 7'h01;
        3'd5: e_stb = 7'h02;
        3'd3: begin e_stb = 7'h04; e_line = d[2:0]; end
        3'd6: begin e_stb = 7'h08; e_line = d[2:0]; end
        3'd7: begin e_stb = 7'h10; e_line = d[2:0]; end
        default: ;
      endcase
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] last_rd;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk({mask_reg, vec_base, init_phase, auto_eoi, rot_on_aeoi, nested_mode, special_mask,
         read_isr, poll_armed, cmd_stb, cmd_line, rdata} == '0, "R1 reset state",
        {mask_reg, cmd_stb}, 0);

    e_mask = 0; e_base = 0; e_phase = 0; e_need = 0; e_aeoi = 0; e_nest = 0;
    e_rot = 0; e_smm = 0; e_rsel = 0; e_poll = 0;

    // R2 R5 R6 R7: sweep every address-0 byte
    for (int v = 0; v < 256; v++) begin
      model_wr0(8'(v));
      wr(1'b0, 8'(v));
      chk(cmd_stb == e_stb && cmd_line == e_line, "R6 R2 R7 strobe/line",
          {cmd_stb, 1'b0, cmd_line}, {e_stb, 1'b0, e_line});
      chk({rot_on_aeoi, special_mask, read_isr, poll_armed, init_phase, mask_reg, vec_base} ==
          {e_rot, e_smm, e_rsel, e_poll, e_phase, e_mask, e_base}, "R5 R2 flags",
          {rot_on_aeoi, special_mask, read_isr, poll_armed, init_phase},
          {e_rot, e_smm, e_rsel, e_poll, e_phase});
    end
    // R7 strobe lasts one cycle
    wr(1'b0, 8'h20);
    chk(cmd_stb == 7'h01, "R7 eoi strobe", cmd_stb, 7'h01);
    @(negedge clk);
    chk(cmd_stb == 7'h00, "R7 strobe one cycle", cmd_stb, 0);

    // R3 four-byte sequence (last sweep byte 0xFF started init with mode byte expected)
    wr(1'b1, 8'hA8);
    chk(vec_base == 5'h15 && init_phase == 2'd2 && mask_reg == 0, "R3 base load",
        {vec_base, init_phase}, {5'h15, 2'd2});
    wr(1'b1, 8'h5C);
    chk(init_phase == 2'd3 && mask_reg == 0, "R3 to mode step", init_phase, 3);
    wr(1'b1, 8'h12);
    chk(init_phase == 0 && nested_mode && auto_eoi && mask_reg == 0, "R3 mode byte",
        {init_phase, nested_mode, auto_eoi}, {2'd0, 2'b11});
    // R3 three-byte sequence
    wr(1'b0, 8'h10);
    chk(init_phase == 2'd1 && !auto_eoi && !nested_mode && vec_base == 0 && cmd_stb == 7'h40,
        "R2 init clears", {init_phase, auto_eoi, nested_mode, cmd_stb}, {2'd1, 2'b00, 7'h40});
    wr(1'b1, 8'h47);
    wr(1'b1, 8'hFF);
    chk(init_phase == 0 && vec_base == 5'd8 && mask_reg == 0 && !auto_eoi && !nested_mode,
        "R3 short sequence", {init_phase, vec_base, mask_reg}, {2'd0, 5'd8, 8'd0});

    // R4 R9 mask load and read back
    for (int v = 0; v < 256; v++) begin
      wr(1'b1, 8'(v));
      chk(mask_reg == 8'(v), "R4 mask load", mask_reg, v);
      rd(1'b1);
      chk(rdata == 8'(v), "R9 mask read", rdata, v);
    end

    // R9 pending / in-service select
    pend_in = 8'h5A; insvc_in = 8'hC3;
    wr(1'b0, 8'h0A);
    rd(1'b0);
    chk(rdata == 8'h5A, "R9 pending read", rdata, 8'h5A);
    wr(1'b0, 8'h0B);
    rd(1'b0);
    chk(rdata == 8'hC3, "R9 in-service read", rdata, 8'hC3);

    // R8 R10 poll for every line
    for (int l = 0; l < 8; l++) begin
      best_valid = 1'b1; best_line = 3'(l);
      #1;
      chk(vector == 8'((8 << 3) | l), "R10 vector", vector, (8 << 3) | l);
      wr(1'b0, 8'h0C);
      chk(poll_armed, "R8 poll armed", poll_armed, 1);
      rd(1'b0);
      chk(rdata == 8'(l) && cmd_stb == 7'h20 && cmd_line == 3'(l) && !poll_armed,
          "R8 poll hit", {rdata, cmd_stb, cmd_line}, {8'(l), 7'h20, 3'(l)});
      rd(1'b0);
      chk(rdata == 8'hC3 && cmd_stb == 0, "R8 poll disarmed", rdata, 8'hC3);
    end
    best_valid = 1'b0;
    wr(1'b0, 8'h0C);
    rd(1'b1);
    chk(rdata == 8'h07 && cmd_stb == 0 && !poll_armed, "R8 poll empty",
        {rdata, cmd_stb}, {8'h07, 7'h0});

    // R11 read with write in the same cycle
    wr(1'b0, 8'h0C);
    last_rd = rdata;
    @(negedge clk); addr = 1'b1; wdata = 8'h33; wr_en = 1'b1; rd_en = 1'b1;
    @(negedge clk); wr_en = 1'b0; rd_en = 1'b0;
    chk(mask_reg == 8'h33 && poll_armed && rdata == last_rd && cmd_stb == 0,
        "R11 read dropped", {mask_reg, rdata, poll_armed}, {8'h33, last_rd, 1'b1});

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule